// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block sits between the fetch stage and the floating-point execution pipe. Each cycle it may be handed a window of instruction bytes that starts at the opcode, together with a bit that says whether the floating-point unit is switched on. One cycle later it returns a dispatch record. The record carries one of four outcomes: the window is not a floating-point instruction, a single-precision operation to execute, an unimplemented-instruction trap, or a unit-disabled trap. When the outcome is an operation, the record also gives the operation class, the 5-bit register indices of the sources and the destination, the instruction length and, if present, the 32-bit immediate.

Each register index is 5 bits wide. The top bit of an index comes from a separate bank-extension bit, and the low four bits come from a register nibble. Only single-precision arithmetic is executed. Double-precision forms, format conversions and any unknown operation byte under a floating-point prefix produce the unimplemented-instruction trap. This lets software emulate those operations. The arithmetic itself, operand reads and trap vectoring belong to other blocks.

Top module: `fpu_dec_top`

## Requirements
- R1: When `fpu_en` is 0 and byte 0 is 0xF9, 0xFB or 0xFE, the outcome is the disabled trap (kind code 3), whatever the other bytes hold. The length is still reported as in R2.
- R2: The length comes from byte 0 alone: 0xF9 gives 3, 0xFB gives 4 and 0xFE gives 7. Any other byte 0 gives kind code 0 (not floating-point) and length 0. Byte k of the window is `in_win[8k+7:8k]`.
- R3: Two-register form, prefix 0xF9. Byte 1 in 0x60..0x67 or 0x70..0x77 executes (kind code 1). Byte 1 bit 4 and bit 2 select add (op 0), sub (op 1), mul (op 2) or div (op 3), read as the two-bit code {bit4, bit2}. The extension bits are Y = byte 1 bit 1 and X = byte 1 bit 0. Source a and the destination are both {X, byte2[3:0]}, and source b is {Y, byte2[7:4]}.
- R4: Three-register form, prefix 0xFB. Byte 1 equal to 0x60, 0x64, 0x70 or 0x74, with byte 3 bit 0 clear, executes with the op code of R3. The register fields are first = {byte3 bit3, byte2[7:4]}, second = {byte3 bit2, byte2[3:0]} and destination = {byte3 bit1, byte3[7:4]}. For add and mul, source a is the first field and source b the second. For sub and div, the two are swapped, so the result is second minus first, or second divided by first.
- R5: Fused multiply-add, prefix 0xFB. Byte 1 in 0x80..0x87 or 0x90..0x97 executes. The op is 4 + {byte1 bit4, byte1 bit2}, which gives 4 madd, 5 msub, 6 negated madd and 7 negated msub. The sources are a = {byte3 bit3, byte2[7:4]}, b = {byte3 bit2, byte2[3:0]} and c = {byte3 bit1, byte3[7:4]}. The destination is {byte3 bit0, byte1[1:0], 2'b00}.
- R6: Immediate form, prefix 0xFE. Byte 1 is decoded as in R3, with the same op and the same Y and X bits. Source a is {Y, byte2[7:4]} and the destination is {X, byte2[3:0]}. `out_imm_sel` is 1 and `out_imm` is bytes 3..6 taken little-endian, with byte 3 as the least significant byte.
- R7: Double-precision forms and conversions raise the unimplemented trap (kind code 2) when the unit is enabled. These are prefix 0xF9 with byte 1 0xF0..0xF7, and prefix 0xFB with byte 1 0xE0, 0xE4, 0xF0, 0xF4, 0x40, 0x42, 0x52 or 0x56.
- R8: Any other byte 1 under a floating-point prefix also gives kind code 2. This includes 0xFB forms from R4 whose byte 3 bit 0 is set. Whenever the kind is not 1, op, all register indices, `out_imm_sel` and `out_imm` are 0.
- R9: The record appears on the first clock edge after a cycle with `in_valid` high. `out_valid` is high in exactly that cycle. While `in_valid` is low, the record fields hold their value. A synchronous active-low reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window holds an instruction to decode |
| in_win | input | 56 | Instruction bytes; byte 0 in bits 7:0 |
| fpu_en | input | 1 | Floating-point unit switched on |
| out_valid | output | 1 | Record produced this cycle |
| out_kind | output | 2 | 0 not floating-point, 1 execute, 2 unimplemented trap, 3 disabled trap |
| out_op | output | 3 | Operation class (R3, R5) |
| out_len | output | 3 | Instruction length in bytes |
| out_src_a | output | 5 | First source register index |
| out_src_b | output | 5 | Second source register index |
| out_src_c | output | 5 | Addend register index (fused forms) |
| out_dst | output | 5 | Destination register index |
| out_imm_sel | output | 1 | Source b is the immediate |
| out_imm | output | 32 | Immediate value |

## Verification
The bench builds the block with its default parameters: a seven-byte window and a 32-bit immediate. With these values all three prefixes reach their full length, and the whole immediate can be compared byte for byte. Random windows are weighted toward the operation bytes around the decode boundaries, such as 0x63/0x64, 0x87/0x88 and 0x9F. They also toggle the bank-extension bits and the reserved bit of byte 3. Directed cases cover the disabled unit combined with a malformed opcode, and a hold cycle with no valid input.

// File: rtl/fpu_dec_pkg.sv
// Shared types for the floating-point instruction decoder.
// Assumes a 5-bit single-precision register index made of one bank bit and a 4-bit nibble.
package fpu_dec_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 5;
    localparam int NIB_W  = REG_W - 1;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_EXEC  = 2'd1,
        K_UNIMP = 2'd2,
        K_OFF   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_DIV   = 3'd3,
        OP_MADD  = 3'd4,
        OP_MSUB  = 3'd5,
        OP_NMADD = 3'd6,
        OP_NMSUB = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        F_NONE  = 2'd0,
        F_TWO   = 2'd1,
        F_THREE = 2'd2,
        F_IMM   = 2'd3
    } fmt_e;
endpackage

// File: rtl/fpu_dec_prefix.sv
// Classifies the first byte of the window into an instruction format and a length.
// Assumes the three prefix codes are distinct; any other byte is not a floating-point opcode.
module fpu_dec_prefix
    import fpu_dec_pkg::*;
#(
    parameter logic [7:0] PFX_TWO   = 8'hF9,
    parameter logic [7:0] PFX_THREE = 8'hFB,
    parameter logic [7:0] PFX_IMM   = 8'hFE,
    parameter int         LEN_W     = 3,
    parameter int         LEN_TWO   = 3,
    parameter int         LEN_THREE = 4,
    parameter int         LEN_IMM   = 7
) (
    input  logic [BYTE_W-1:0] pfx,
    output fmt_e              fmt,
    output logic [LEN_W-1:0]  len,
    output logic              is_fpu
);
    // Map the prefix byte onto format and byte count.
    always_comb begin
        fmt = F_NONE;
        len = '0;
        unique case (pfx)
            PFX_TWO: begin
                fmt = F_TWO;
                len = LEN_W'(LEN_TWO);
            end
            PFX_THREE: begin
                fmt = F_THREE;
                len = LEN_W'(LEN_THREE);
            end
            PFX_IMM: begin
                fmt = F_IMM;
                len = LEN_W'(LEN_IMM);
            end
            default: ;
        endcase
        is_fpu = (fmt != F_NONE);
    end
endmodule

// File: rtl/fpu_dec_ops.sv
// Decodes the operation byte and register bytes for a known format into kind, op and indices.
// Assumes the format is already resolved; the disabled check overrides all operation decoding.
module fpu_dec_ops
    import fpu_dec_pkg::*;
(
    input  fmt_e              fmt,
    input  logic              fpu_en,
    input  logic [BYTE_W-1:0] b1,
    input  logic [BYTE_W-1:0] b2,
    input  logic [BYTE_W-1:0] b3,
    output kind_e             kind,
    output op_e               op,
    output logic [REG_W-1:0]  src_a,
    output logic [REG_W-1:0]  src_b,
    output logic [REG_W-1:0]  src_c,
    output logic [REG_W-1:0]  dst,
    output logic              imm_sel
);
    logic             basic_op;   // byte 1 names add/sub/mul/div with bank bits in 1:0
    logic             three_op;   // byte 1 is an exact three-register single code
    logic             fused_op;   // byte 1 is in the fused family
    logic [REG_W-1:0] fld1;
    logic [REG_W-1:0] fld2;

    // Recognise the operation byte families.
    always_comb begin
        basic_op = (b1[7:5] == 3'b011) && !b1[3];
        three_op = basic_op && (b1[1:0] == 2'b00) && !b3[0];
        fused_op = (b1[7:5] == 3'b100) && !b1[3];
        fld1     = {b3[3], b2[7:4]};
        fld2     = {b3[2], b2[3:0]};
    end

    // Build the dispatch fields for the selected format.
    always_comb begin
        kind    = K_NONE;
        op      = OP_ADD;
        src_a   = '0;
        src_b   = '0;
        src_c   = '0;
        dst     = '0;
        imm_sel = 1'b0;
        if (fmt != F_NONE) begin
            if (!fpu_en) begin
                kind = K_OFF;
            end else begin
                kind = K_UNIMP;
                unique case (fmt)
                    F_TWO, F_IMM: begin
                        if (basic_op) begin
                            kind = K_EXEC;
                            op   = op_e'({1'b0, b1[4], b1[2]});
                            dst  = {b1[0], b2[3:0]};
                            if (fmt == F_TWO) begin
                                src_a = {b1[0], b2[3:0]};
                                src_b = {b1[1], b2[7:4]};
                            end else begin
                                src_a   = {b1[1], b2[7:4]};
                                imm_sel = 1'b1;
                            end
                        end
                    end
                    F_THREE: begin
                        if (three_op) begin
                            kind  = K_EXEC;
                            op    = op_e'({1'b0, b1[4], b1[2]});
                            src_a = b1[2] ? fld2 : fld1;
                            src_b = b1[2] ? fld1 : fld2;
                            dst   = {b3[1], b3[7:4]};
                        end else if (fused_op) begin
                            kind  = K_EXEC;
                            op    = op_e'({1'b1, b1[4], b1[2]});
                            src_a = fld1;
                            src_b = fld2;
                            src_c = {b3[1], b3[7:4]};
                            dst   = {b3[0], b1[1:0], {(REG_W-3){1'b0}}};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpu_dec_imm.sv
// Gathers the immediate from consecutive window bytes, least significant byte first.
// Assumes the immediate fits inside the window after its first byte.
module fpu_dec_imm
    import fpu_dec_pkg::*;
#(
    parameter int WIN_BYTES = 7,
    parameter int IMM_W     = 32,
    parameter int FIRST     = 3
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] win,
    output logic [IMM_W-1:0]            imm
);
    localparam int IMM_BYTES = IMM_W / BYTE_W;

    // One byte lane per immediate byte.
    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_lane
        assign imm[k*BYTE_W +: BYTE_W] = win[(FIRST+k)*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/fpu_dec_top.sv
// Floating-point instruction decoder: registers one dispatch record per valid window.
// Assumes byte 0 of the window is the opcode prefix and the window always covers the longest form.
module fpu_dec_top
    import fpu_dec_pkg::*;
#(
    parameter int IMM_W     = 32,
    parameter int WIN_BYTES = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WIN_BYTES*BYTE_W-1:0] in_win,
    input  logic                        fpu_en,
    output logic                        out_valid,
    output logic [1:0]                  out_kind,
    output logic [2:0]                  out_op,
    output logic [2:0]                  out_len,
    output logic [REG_W-1:0]            out_src_a,
    output logic [REG_W-1:0]            out_src_b,
    output logic [REG_W-1:0]            out_src_c,
    output logic [REG_W-1:0]            out_dst,
    output logic                        out_imm_sel,
    output logic [IMM_W-1:0]            out_imm
);
    localparam int IMM_BYTES = IMM_W / BYTE_W;
    localparam int LEN_TWO   = 3;
    localparam int LEN_THREE = 4;
    localparam int LEN_IMM   = 3 + IMM_BYTES;
    localparam int LEN_W     = 3;

    fmt_e             fmt;
    logic [LEN_W-1:0] len_d;
    logic             is_fpu;
    kind_e            kind_d;
    op_e              op_d;
    logic [REG_W-1:0] a_d, b_d, c_d, dst_d;
    logic             sel_d;
    logic [IMM_W-1:0] imm_raw;

    fpu_dec_prefix #(
        .LEN_W    (LEN_W),
        .LEN_TWO  (LEN_TWO),
        .LEN_THREE(LEN_THREE),
        .LEN_IMM  (LEN_IMM)
    ) i_prefix (
        .pfx   (in_win[0 +: BYTE_W]),
        .fmt   (fmt),
        .len   (len_d),
        .is_fpu(is_fpu)
    );

    fpu_dec_ops i_ops (
        .fmt    (fmt),
        .fpu_en (fpu_en),
        .b1     (in_win[1*BYTE_W +: BYTE_W]),
        .b2     (in_win[2*BYTE_W +: BYTE_W]),
        .b3     (in_win[3*BYTE_W +: BYTE_W]),
        .kind   (kind_d),
        .op     (op_d),
        .src_a  (a_d),
        .src_b  (b_d),
        .src_c  (c_d),
        .dst    (dst_d),
        .imm_sel(sel_d)
    );

    fpu_dec_imm #(
        .WIN_BYTES(WIN_BYTES),
        .IMM_W    (IMM_W),
        .FIRST    (3)
    ) i_imm (
        .win(in_win),
        .imm(imm_raw)
    );

    // Capture the record for a valid window; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_kind    <= '0;
            out_op      <= '0;
            out_len     <= '0;
            out_src_a   <= '0;
            out_src_b   <= '0;
            out_src_c   <= '0;
            out_dst     <= '0;
            out_imm_sel <= 1'b0;
            out_imm     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_kind    <= kind_d;
                out_op      <= op_d;
                out_len     <= len_d;
                out_src_a   <= a_d;
                out_src_b   <= b_d;
                out_src_c   <= c_d;
                out_dst     <= dst_d;
                out_imm_sel <= sel_d;
                out_imm     <= sel_d ? imm_raw : '0;
            end
        end
    end

    // R1: a disabled unit wins over every other outcome.
    a_r1_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fpu_en && is_fpu) |=> (out_valid && out_kind == K_OFF));

    // R2: foreign prefixes give no kind and no length.
    a_r2_foreign_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_fpu) |=> (out_kind == K_NONE && out_len == '0));

    // R8: non-executing records carry no operands.
    a_r8_trap_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind != K_EXEC) |-> (out_op == '0 && out_src_a == '0 && out_src_b == '0
                                  && out_src_c == '0 && out_dst == '0 && !out_imm_sel
                                  && out_imm == '0));

    // R6: the immediate appears only on a seven-byte executing record.
    a_r6_imm_long: assert property (@(posedge clk) disable iff (!rst_n)
        out_imm_sel |-> (out_kind == K_EXEC && out_len == LEN_W'(LEN_IMM)));

    // R5: the third source is used by the fused family only.
    a_r5_c_fused_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == K_EXEC && !out_op[2]) |-> (out_src_c == '0));

    // R9: no valid input means no record and unchanged fields.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_kind) && $stable(out_dst)
                       && $stable(out_len)));
endmodule

// File: tb/test_fpu_dec_top.sv
// Self-checking bench: seeded random windows plus directed corners, compared to a bench model.
module test_fpu_dec_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [55:0] in_win = '0;
    logic        fpu_en = 1'b0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [2:0]  out_op;
    logic [2:0]  out_len;
    logic [4:0]  out_src_a, out_src_b, out_src_c, out_dst;
    logic        out_imm_sel;
    logic [31:0] out_imm;

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  op;
        logic [2:0]  len;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [4:0]  c;
        logic [4:0]  d;
        logic        sel;
        logic [31:0] imm;
    } rec_t;

    fpu_dec_top i_fpu_dec_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win), .fpu_en(fpu_en),
        .out_valid(out_valid), .out_kind(out_kind), .out_op(out_op), .out_len(out_len),
        .out_src_a(out_src_a), .out_src_b(out_src_b), .out_src_c(out_src_c),
        .out_dst(out_dst), .out_imm_sel(out_imm_sel), .out_imm(out_imm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected record written from the requirement text.
    function automatic rec_t model(input logic [55:0] w, input logic en, output string tag);
        rec_t r;
        logic [7:0] p, o, g, h;
        p = w[7:0]; o = w[15:8]; g = w[23:16]; h = w[31:24];
        r = '0;
        tag = "R8";
        if (p == 8'hF9) r.len = 3;
        else if (p == 8'hFB) r.len = 4;
        else if (p == 8'hFE) r.len = 7;
        else begin tag = "R2"; return r; end
        if (!en) begin r.kind = 3; tag = "R1"; return r; end
        r.kind = 2;
        if ((p == 8'hF9 && o >= 8'hF0 && o <= 8'hF7) ||
            (p == 8'hFB && (o == 8'hE0 || o == 8'hE4 || o == 8'hF0 || o == 8'hF4 ||
                            o == 8'h40 || o == 8'h42 || o == 8'h52 || o == 8'h56))) begin
            tag = "R7";
            return r;
        end
        if (p != 8'hFB && ((o >= 8'h60 && o <= 8'h67) || (o >= 8'h70 && o <= 8'h77))) begin
            r.kind = 1;
            r.op = ((o >= 8'h70) ? 3'd2 : 3'd0) + ((o >= 8'h64 && o <= 8'h67) || o >= 8'h74 ? 3'd1 : 3'd0);
            r.d = {o[0], g[3:0]};
            if (p == 8'hF9) begin
                tag = "R3";
                r.a = {o[0], g[3:0]};
                r.b = {o[1], g[7:4]};
            end else begin
                tag = "R6";
                r.a = {o[1], g[7:4]};
                r.sel = 1'b1;
                r.imm = {w[55:48], w[47:40], w[39:32], w[31:24]};
            end
        end else if (p == 8'hFB && (o == 8'h60 || o == 8'h64 || o == 8'h70 || o == 8'h74)) begin
            tag = "R4";
            if (h[0] == 1'b0) begin
                r.kind = 1;
                r.op = (o == 8'h60) ? 3'd0 : (o == 8'h64) ? 3'd1 : (o == 8'h70) ? 3'd2 : 3'd3;
                if (o == 8'h64 || o == 8'h74) begin
                    r.a = {h[2], g[3:0]}; r.b = {h[3], g[7:4]};
                end else begin
                    r.a = {h[3], g[7:4]}; r.b = {h[2], g[3:0]};
                end
                r.d = {h[1], h[7:4]};
            end
        end else if (p == 8'hFB && ((o >= 8'h80 && o <= 8'h87) || (o >= 8'h90 && o <= 8'h97))) begin
            tag = "R5";
            r.kind = 1;
            r.op = 3'd4 + ((o >= 8'h90) ? 3'd2 : 3'd0) + ((o[3:0] >= 4'h4) ? 3'd1 : 3'd0);
            r.a = {h[3], g[7:4]};
            r.b = {h[2], g[3:0]};
            r.c = {h[1], h[7:4]};
            r.d = {h[0], o[1:0], 2'b00};
        end
        return r;
    endfunction

    function automatic rec_t actual();
        return {out_kind, out_op, out_len, out_src_a, out_src_b, out_src_c, out_dst,
                out_imm_sel, out_imm};
    endfunction

    task automatic expect_rec(input rec_t exp, input string tag);
        rec_t act;
        act = actual();
        checks++;
        if (act !== exp || out_valid !== 1'b1) begin
            failures++;
            $display("FAIL %s: win=%h act=%h valid=%b exp=%h", tag, in_win, act, out_valid, exp);
        end
    endtask

    // Drive one window at a falling edge and check the record at the next falling edge.
    task automatic run_one(input logic [55:0] w, input logic en);
        rec_t exp;
        string tag;
        in_valid = 1'b1;
        in_win = w;
        fpu_en = en;
        exp = model(w, en, tag);
        @(posedge clk);
        @(negedge clk);
        expect_rec(exp, tag);
    endtask

    function automatic logic [7:0] pick_op();
        logic [7:0] lst [24] = '{8'h60, 8'h63, 8'h64, 8'h67, 8'h70, 8'h73, 8'h74, 8'h77,
                                 8'h68, 8'h78, 8'h80, 8'h84, 8'h87, 8'h88, 8'h90, 8'h97,
                                 8'h9F, 8'hE0, 8'hE4, 8'hF0, 8'hF4, 8'h40, 8'h52, 8'h56};
        if ($urandom % 4 == 0) return 8'($urandom);
        return lst[$urandom % 24];
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        rec_t held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R9: reset clears every output.
        checks++;
        if (out_valid !== 1'b0 || actual() !== '0) begin
            failures++;
            $display("FAIL R9 reset act=%h valid=%b exp=0", actual(), out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        run_one({32'h0, 8'h00, 8'h3A, 8'h76, 8'hF9}, 1'b1);              // R3 div with Y set
        run_one({32'h0, 8'h5E, 8'h12, 8'h64, 8'hFB}, 1'b1);              // R4 sub swaps sources
        run_one({32'h0, 8'h5F, 8'h12, 8'h70, 8'hFB}, 1'b1);              // R8 reserved bit set
        run_one({32'h0, 8'hC7, 8'hAB, 8'h97, 8'hFB}, 1'b1);              // R5 negated msub
        run_one({32'hDEADBEEF, 8'h5C, 8'h65, 8'hFE}, 1'b1);              // R6 sub with immediate
        run_one({32'h0, 8'h00, 8'h00, 8'hE4, 8'hFB}, 1'b1);              // R7 double form
        run_one({32'h0, 8'h00, 8'h11, 8'h42, 8'hFB}, 1'b1);              // R7 conversion
        run_one({32'h0, 8'h00, 8'h11, 8'hFF, 8'hFB}, 1'b0);              // R1 off beats bad op
        run_one({32'h0, 8'h00, 8'h11, 8'h60, 8'hF8}, 1'b1);              // R2 foreign prefix
        run_one({32'h0, 8'h00, 8'h11, 8'h88, 8'hFB}, 1'b1);              // R8 unknown fused code

        // R9: a cycle without valid input keeps the record and drops out_valid.
        held = actual();
        in_valid = 1'b0;
        in_win = {32'h0, 8'h00, 8'h11, 8'h60, 8'hF9};
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || actual() !== held) begin
            failures++;
            $display("FAIL R9 hold act=%h valid=%b exp=%h valid=0", actual(), out_valid, held);
        end

        // Seeded random windows.
        for (int n = 0; n < 400; n++) begin
            logic [55:0] w;
            logic [7:0]  p;
            int          s;
            s = $urandom % 8;
            p = (s < 2) ? 8'hF9 : (s < 5) ? 8'hFB : (s < 7) ? 8'hFE : 8'($urandom);
            w = {$urandom, 8'($urandom), 8'($urandom), pick_op(), p};
            run_one(w, ($urandom % 10) != 0);
        end

        in_valid = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule